// File: doc/BRIEF.md
# Restart Vector Interrupt Merger

This block gathers interrupt requests from a small set of sources and hands a processor one 8-bit vector byte and one level-sensitive interrupt line. During its acknowledge cycle, the processor fetches the byte and executes it as a single-byte restart instruction. Each source raises its request with a one-cycle set pulse and withdraws it with a one-cycle clear pulse. A global init pulse returns the whole block to idle.

In the default mode, every active source drives its own restart opcode, and the vector is the bitwise AND of all contributions. An idle source contributes 0xFF. The result is the byte a pulled-up, open-drain data bus would carry if every requester drove it at once. No priority encoder chooses between sources.

Two other modes are chosen when init is applied:
- Mask mode: each source clears one bit of an otherwise all-ones byte.
- Priority mode: a pending register picks one of a few fixed vectors. When nothing is pending, the last vector stays on the output and only the line drops.

Top module: `irq_vec_merger`

## Requirements
- R1: After reset, and on the first clock edge after an init pulse, vector_o reads 0xFF, irq_o is low and every source is idle.
- R2: mode_i is sampled only in a cycle where init_i is high. 0 selects AND-merge, 1 selects mask mode, 2 selects priority mode, and 3 behaves as AND-merge. A change of mode_i without init has no effect on the outputs.
- R3: In AND-merge mode, active source 0 contributes 0xD7 and active source 1 contributes 0xDF. An idle source contributes 0xFF. vector_o is the bitwise AND of all contributions, so with both active it reads 0xD7.
- R4: In AND-merge and mask modes, irq_o is high exactly when vector_o differs from 0xFF.
- R5: In mask mode, active source 0 clears bit 4 and active source 1 clears bit 5 of an all-ones byte. The vector reads 0xEF, 0xDF or 0xCF.
- R6: In priority mode, a pending source 1 gives vector 0x18 whatever source 0 does. Source 0 pending alone gives 0x19. irq_o is high while any source is pending.
- R7: In priority mode, when no source is pending, irq_o is low and vector_o keeps the last value it held.
- R8: A set pulse makes a source active. A clear pulse makes it idle. When set and clear for the same source fall in the same cycle, clear wins.
- R9: init_i overrides any set or clear pulse in the same cycle.
- R10: Both outputs are registered and take their new value on the first clock edge that samples the causing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk_i |
| init_i | input | 1 | One-cycle pulse that returns the block to idle and samples mode_i |
| mode_i | input | 2 | Behaviour select, sampled only with init_i |
| src_set_i | input | NSRC | One-cycle request-assert pulse per source |
| src_clr_i | input | NSRC | One-cycle request-withdraw pulse per source |
| vector_o | output | 8 | Vector byte presented to the processor |
| irq_o | output | 1 | Level interrupt line, active high |

## Verification
The assertions take for granted that events are one-cycle pulses sampled at the rising edge, and that mode_i matters only while init_i is high. The stimulus drives every pulse on the falling edge and holds it for exactly one cycle. Outputs are read on the next falling edge, which follows the single register stage on the path. Collisions are applied on purpose as single-cycle events: set with clear on one source, and init with set. The stimulus also moves mode_i away from its latched value without init, to confirm the outputs ignore it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    MODE_AND     = 2'd0,
    MODE_MASK    = 2'd1,
    MODE_PRIO    = 2'd2,
    MODE_AND_ALT = 2'd3
  } merge_mode_e;

  localparam logic [7:0] VEC_IDLE = 8'hFF;

  // Single-byte restart opcode for restart slot n: 11 nnn 111
  function automatic logic [7:0] rst_opcode(input int n);
    logic [2:0] slot;
    slot = n[2:0];
    return {2'b11, slot, 3'b111};
  endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_d_o,
  output logic pend_q_o
);

  logic pend_d;
  logic pend_q;

  // Priority: init, then clear, then set
  always_comb begin
    pend_d = pend_q;
    if (init_i)      pend_d = 1'b0;
    else if (clr_i)  pend_d = 1'b0;
    else if (set_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q); // R8
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && !init_i) |=> pend_q); // R8
  AST_INIT_OVERRIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !pend_q); // R9

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge
  import irq_vec_pkg::*;
#(
  parameter int         NSRC       = 2,
  parameter int         RST_BASE   = 2,
  parameter int         MASK_BASE  = 4,
  parameter logic [7:0] PRIO_BASE  = 8'h18
) (
  input  merge_mode_e       mode_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [7:0]        vec_o,
  output logic              any_o
);

  logic [7:0] and_contrib  [NSRC];
  logic [7:0] mask_contrib [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_contrib
    localparam logic [7:0] OPC  = rst_opcode(RST_BASE + g);
    localparam logic [7:0] MBIT = 8'h01 << (MASK_BASE + g);
    assign and_contrib[g]  = pend_i[g] ? OPC   : VEC_IDLE;
    assign mask_contrib[g] = pend_i[g] ? ~MBIT : VEC_IDLE;
  end

  logic [7:0] and_vec;
  logic [7:0] mask_vec;
  logic [7:0] prio_vec;

  always_comb begin
    and_vec  = VEC_IDLE;
    mask_vec = VEC_IDLE;
    for (int i = 0; i < NSRC; i++) begin
      and_vec  = and_vec  & and_contrib[i];
      mask_vec = mask_vec & mask_contrib[i];
    end
  end

  // Ascending scan: the highest pending index is written last and wins
  always_comb begin
    prio_vec = VEC_IDLE;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i]) prio_vec = PRIO_BASE + 8'(NSRC - 1 - i);
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_MASK: vec_o = mask_vec;
      MODE_PRIO: vec_o = prio_vec;
      default:   vec_o = and_vec;
    endcase
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/irq_vec_merger.sv
module irq_vec_merger
  import irq_vec_pkg::*;
#(
  parameter int         NSRC      = 2,
  parameter int         RST_BASE  = 2,
  parameter int         MASK_BASE = 4,
  parameter logic [7:0] PRIO_BASE = 8'h18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic [1:0]      mode_i,
  input  logic [NSRC-1:0] src_set_i,
  input  logic [NSRC-1:0] src_clr_i,
  output logic [7:0]      vector_o,
  output logic            irq_o
);

  localparam logic [7:0] PRIO_TOP = PRIO_BASE + 8'(NSRC - 1);

  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_latch u_latch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (init_i),
      .set_i    (src_set_i[g]),
      .clr_i    (src_clr_i[g]),
      .pend_d_o (pend_d[g]),
      .pend_q_o (pend_q[g])
    );
  end

  // Mode register: loaded only by init
  merge_mode_e mode_d;
  merge_mode_e mode_q;

  always_comb begin
    mode_d = mode_q;
    if (init_i) mode_d = merge_mode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_AND;
    else         mode_q <= mode_d;
  end

  // Merge from the next pending state so outputs land one edge after the event
  logic [7:0] vec_calc;
  logic       any_next;

  irq_vec_merge #(
    .NSRC      (NSRC),
    .RST_BASE  (RST_BASE),
    .MASK_BASE (MASK_BASE),
    .PRIO_BASE (PRIO_BASE)
  ) u_merge (
    .mode_i (mode_d),
    .pend_i (pend_d),
    .vec_o  (vec_calc),
    .any_o  (any_next)
  );

  // Output registers with explicit enable on the vector
  logic [7:0] vec_d;
  logic       vec_en;
  logic       irq_d;

  always_comb begin
    vec_en = init_i || (mode_d != MODE_PRIO) || any_next;
    vec_d  = init_i ? VEC_IDLE : vec_calc;
    if (mode_d == MODE_PRIO) irq_d = any_next;
    else                     irq_d = (vec_calc != VEC_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_o <= VEC_IDLE;
      irq_o    <= 1'b0;
    end else begin
      if (vec_en) vector_o <= vec_d;
      irq_o <= irq_d;
    end
  end

  AST_INIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (vector_o == VEC_IDLE && !irq_o && pend_q == '0)); // R1
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> $stable(mode_q)); // R2
  AST_LINE_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_PRIO) |-> (irq_o == (vector_o != VEC_IDLE))); // R4
  AST_PRIO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PRIO && irq_o) |-> (vector_o >= PRIO_BASE && vector_o <= PRIO_TOP)); // R6
  AST_PRIO_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PRIO) |-> (irq_o == (pend_q != '0))); // R6
  AST_PRIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_q == MODE_PRIO && pend_q != '0 && pend_d == '0) |=> $stable(vector_o)); // R7

endmodule

// File: tb/irq_vec_merger_tb.sv
module irq_vec_merger_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       init_i;
  logic [1:0] mode_i;
  logic [1:0] src_set_i;
  logic [1:0] src_clr_i;
  logic [7:0] vector_o;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_vec_merger u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .mode_i    (mode_i),
    .src_set_i (src_set_i),
    .src_clr_i (src_clr_i),
    .vector_o  (vector_o),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] ev, input logic ei);
    n_chk++;
    if (vector_o !== ev || irq_o !== ei) begin
      n_fail++;
      $display("FAIL %s: vector=%02h irq=%0b expected vector=%02h irq=%0b",
               tag, vector_o, irq_o, ev, ei);
    end
  endtask

  // One-cycle event driven on the falling edge; outputs read one falling edge later
  task automatic ev(input logic [1:0] s, input logic [1:0] c, input logic in,
                    input logic [1:0] m);
    @(negedge clk_i);
    src_set_i = s; src_clr_i = c; init_i = in; mode_i = m;
    @(negedge clk_i);
    src_set_i = '0; src_clr_i = '0; init_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", 8'hFF, 1'b0);
  endtask

  task automatic t_and_merge();
    ev(2'b00, 2'b00, 1'b1, 2'd0);
    ev(2'b01, 2'b00, 1'b0, 2'd0); chk("R3 R10 src0 only", 8'hD7, 1'b1);
    ev(2'b10, 2'b00, 1'b0, 2'd0); chk("R3 both active", 8'hD7, 1'b1);
    ev(2'b00, 2'b01, 1'b0, 2'd0); chk("R3 src1 only", 8'hDF, 1'b1);
    ev(2'b00, 2'b10, 1'b0, 2'd0); chk("R4 all idle", 8'hFF, 1'b0);
  endtask

  task automatic t_collisions();
    ev(2'b01, 2'b01, 1'b0, 2'd0); chk("R8 set+clear idle src", 8'hFF, 1'b0);
    ev(2'b01, 2'b00, 1'b0, 2'd0);
    ev(2'b01, 2'b01, 1'b0, 2'd0); chk("R8 set+clear active src", 8'hFF, 1'b0);
    ev(2'b10, 2'b00, 1'b0, 2'd0);
    ev(2'b01, 2'b00, 1'b1, 2'd0); chk("R9 init beats set", 8'hFF, 1'b0);
  endtask

  task automatic t_mode_ignored();
    ev(2'b01, 2'b00, 1'b0, 2'd0);
    ev(2'b00, 2'b00, 1'b0, 2'd2); chk("R2 mode change without init", 8'hD7, 1'b1);
    ev(2'b10, 2'b00, 1'b0, 2'd1); chk("R2 still AND-merge", 8'hD7, 1'b1);
    ev(2'b00, 2'b00, 1'b1, 2'd3);
    ev(2'b10, 2'b00, 1'b0, 2'd3); chk("R2 mode 3 as AND-merge", 8'hDF, 1'b1);
  endtask

  task automatic t_mask();
    ev(2'b00, 2'b00, 1'b1, 2'd1); chk("R1 init in mask mode", 8'hFF, 1'b0);
    ev(2'b01, 2'b00, 1'b0, 2'd1); chk("R5 bit4", 8'hEF, 1'b1);
    ev(2'b10, 2'b00, 1'b0, 2'd1); chk("R5 bits4+5", 8'hCF, 1'b1);
    ev(2'b00, 2'b01, 1'b0, 2'd1); chk("R5 bit5", 8'hDF, 1'b1);
    ev(2'b00, 2'b10, 1'b0, 2'd1); chk("R4 mask idle", 8'hFF, 1'b0);
  endtask

  task automatic t_prio();
    ev(2'b00, 2'b00, 1'b1, 2'd2); chk("R1 init in priority mode", 8'hFF, 1'b0);
    ev(2'b01, 2'b00, 1'b0, 2'd2); chk("R6 src0 alone", 8'h19, 1'b1);
    ev(2'b10, 2'b00, 1'b0, 2'd2); chk("R6 src1 wins", 8'h18, 1'b1);
    ev(2'b00, 2'b10, 1'b0, 2'd2); chk("R6 back to src0", 8'h19, 1'b1);
    ev(2'b00, 2'b01, 1'b0, 2'd2); chk("R7 hold 0x19", 8'h19, 1'b0);
    ev(2'b10, 2'b00, 1'b0, 2'd2); chk("R6 src1 alone", 8'h18, 1'b1);
    ev(2'b00, 2'b10, 1'b0, 2'd2); chk("R7 hold 0x18", 8'h18, 1'b0);
    ev(2'b00, 2'b00, 1'b0, 2'd2); chk("R7 still held", 8'h18, 1'b0);
    ev(2'b00, 2'b00, 1'b1, 2'd0); chk("R1 init clears held vector", 8'hFF, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0; init_i = 1'b0; mode_i = 2'd0;
    src_set_i = '0; src_clr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_and_merge();
    t_collisions();
    t_mode_ignored();
    t_mask();
    t_prio();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule